// File: doc/BRIEF.md
# Counter-Target Wait Stall Unit

This unit carries out the "wait until the system counter reaches a target" instruction of a pipelined processor. When the pipeline issues the instruction it raises `start` for one cycle and presents two operands. The destination operand is the target count and the source operand is the period. The unit latches both operands. It spends two cycles in operand stages and then compares the free-running system counter with the target on every cycle. It holds the pipeline stalled until the two are exactly equal.

After a match the unit takes one further stalled cycle to propagate the release. In the cycle after that it drops `stall` and writes `target + period` back. A loop can therefore schedule its next wake-up a fixed period later. The pipeline is stalled, never flushed. The instruction that follows has already been fetched when the writeback happens, and it may be another wait that starts in the writeback cycle itself.

The compare tests for equality and never for greater-or-equal. A target that the counter has already passed when comparison begins costs a full wrap of the counter. The counter width is a parameter, which lets a narrow counter make that wrap short enough to measure.

Top module: `cntwait_unit`

## Requirements
- R1: After reset, `stall`, `wb_en` and `wb_data` are all zero, and the unit is idle.
- R2: When `start` is high in a cycle where `stall` is low (idle or the writeback cycle), `stall` is high in the following cycle and stays high until the release described in R9.
- R3: `dst` and `src` are captured in the cycle `start` is accepted. Changes to them while `stall` is high have no effect on the release cycle or on the written value.
- R4: Comparison starts in the fourth cycle of the instruction (cycle 3, counting the `start` cycle as cycle 0). It releases only on a cycle where `cnt` equals the captured target in all bits.
- R5: A target equal to the counter value seen in cycle 3 gives the shortest execution, 6 cycles: `wb_en` is high in cycle 5.
- R6: With lead d = target minus the counter value in cycle 0, taken modulo 2^CW, and with d of 3 or more, `wb_en` is high in cycle d+2.
- R7: With d below 3 (the target is already passed when comparison starts), the unit waits a full wrap: `wb_en` is high in cycle d+2+2^CW.
- R8: While `wb_en` is high, `wb_data` equals (captured dst + captured src) modulo 2^CW. While `wb_en` is low, `wb_data` is zero.
- R9: `wb_en` is high for exactly one cycle, two cycles after the matching compare cycle. `stall` is low in that cycle.
- R10: A `start` pulse while `stall` is high is ignored.
- R11: A `start` in the writeback cycle begins a new wait at once, timed as in R5 to R7 from that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue strobe for the wait instruction |
| cnt | input | CW | Free-running system counter |
| dst | input | CW | Destination operand: target count |
| src | input | CW | Source operand: period added at writeback |
| stall | output | 1 | Pipeline stall request |
| wb_en | output | 1 | Writeback enable, one cycle |
| wb_data | output | CW | Writeback value (next target) |

## Verification
Counting the `start` cycle as cycle 0, `stall` is due in cycle 1. The writeback is due in cycle d+2, or in cycle d+2+2^CW when the lead d is below 3, and `stall` is low in that same cycle. The bench drives every input on the falling edge and reads the outputs one falling edge per cycle. It numbers those cycles from the launch and compares the first cycle with `wb_en` high to the expected number computed from the lead. It then reads `wb_data` and `stall` in that same sample, and reads `wb_en` again one sample later. Disturbances of the operands or of `start` are applied at fixed cycle numbers inside the stall window, so the expected release cycle stays the one computed at launch.

// File: rtl/cntwait_pkg.sv
package cntwait_pkg;

  typedef enum logic [2:0] {
    WS_IDLE   = 3'd0,
    WS_OPER_A = 3'd1,
    WS_OPER_B = 3'd2,
    WS_CMP    = 3'd3,
    WS_SETTLE = 3'd4,
    WS_WRITE  = 3'd5
  } wstate_e;

  // Number of cycles from the accepted start to the first compare.
  localparam int FIRST_CMP_CYCLE = 3;
  // Cycles from the matching compare to the writeback cycle.
  localparam int RELEASE_DELAY   = 2;

  function automatic logic is_stalling(wstate_e s);
    return (s == WS_OPER_A) || (s == WS_OPER_B) ||
           (s == WS_CMP)    || (s == WS_SETTLE);
  endfunction

  function automatic logic can_accept(wstate_e s);
    return (s == WS_IDLE) || (s == WS_WRITE);
  endfunction

endpackage

// File: rtl/cntwait_operands.sv
module cntwait_operands #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] dst,
  input  logic [CW-1:0] src,
  output logic [CW-1:0] tgt_q,
  output logic [CW-1:0] inc_q,
  output logic [CW-1:0] sum_q
);

  function automatic logic [CW-1:0] next_target(logic [CW-1:0] t, logic [CW-1:0] p);
    logic [CW:0] wide;
    wide = {1'b0, t} + {1'b0, p};
    return wide[CW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      inc_q <= '0;
      sum_q <= '0;
    end else if (load) begin
      tgt_q <= dst;
      inc_q <= src;
      sum_q <= next_target(dst, src);
    end
  end

endmodule

// File: rtl/cntwait_compare.sv
module cntwait_compare #(
  parameter int CW = 32
) (
  input  logic          en,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] tgt,
  output logic          hit
);

  function automatic logic exact_match(logic [CW-1:0] a, logic [CW-1:0] b);
    return ((a ^ b) == '0);
  endfunction

  always_comb hit = en && exact_match(cnt, tgt);

endmodule

// File: rtl/cntwait_ctrl.sv
module cntwait_ctrl
  import cntwait_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    hit,
  output wstate_e state,
  output logic    accept,
  output logic    cmp_en,
  output logic    stall,
  output logic    wb_en
);

  wstate_e state_nx;

  always_comb begin
    accept = start && can_accept(state);
    cmp_en = (state == WS_CMP);
    stall  = is_stalling(state);
    wb_en  = (state == WS_WRITE);
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      WS_IDLE:   if (accept) state_nx = WS_OPER_A;
      WS_OPER_A: state_nx = WS_OPER_B;
      WS_OPER_B: state_nx = WS_CMP;
      WS_CMP:    if (hit) state_nx = WS_SETTLE;
      WS_SETTLE: state_nx = WS_WRITE;
      WS_WRITE:  state_nx = accept ? WS_OPER_A : WS_IDLE;
      default:   state_nx = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/cntwait_unit.sv
module cntwait_unit
  import cntwait_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] dst,
  input  logic [CW-1:0] src,
  output logic          stall,
  output logic          wb_en,
  output logic [CW-1:0] wb_data
);

  wstate_e       state;
  logic          accept;
  logic          cmp_en;
  logic          hit;
  logic          in_settle;
  logic [CW-1:0] tgt_q;
  logic [CW-1:0] inc_q;
  logic [CW-1:0] sum_q;

  cntwait_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .hit    (hit),
    .state  (state),
    .accept (accept),
    .cmp_en (cmp_en),
    .stall  (stall),
    .wb_en  (wb_en)
  );

  cntwait_operands #(.CW(CW)) u_ops (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .dst   (dst),
    .src   (src),
    .tgt_q (tgt_q),
    .inc_q (inc_q),
    .sum_q (sum_q)
  );

  cntwait_compare #(.CW(CW)) u_cmp (
    .en  (cmp_en),
    .cnt (cnt),
    .tgt (tgt_q),
    .hit (hit)
  );

  always_comb begin
    in_settle = (state == WS_SETTLE);
    wb_data   = wb_en ? sum_q : '0;
  end

endmodule

// File: rtl/cntwait_unit_chk.sv
module cntwait_unit_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stall,
  input logic          wb_en,
  input logic [CW-1:0] wb_data,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] tgt_q,
  input logic [CW-1:0] inc_q,
  input logic          in_settle
);

  AST_STALL_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stall) |=> stall); // R2

  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> ($stable(tgt_q) && $stable(inc_q))); // R3

  AST_EXACT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    in_settle |-> ($past(cnt) == $past(tgt_q))); // R4

  AST_WB_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data == CW'(tgt_q + inc_q))); // R8

  AST_WB_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_en |-> (wb_data == '0)); // R8

  AST_SETTLE_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    in_settle |=> (wb_en && !stall)); // R9

  AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en); // R9

  AST_WB_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !stall); // R9

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !in_settle) |=> stall); // R10

endmodule

bind cntwait_unit cntwait_unit_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stall     (stall),
  .wb_en     (wb_en),
  .wb_data   (wb_data),
  .cnt       (cnt),
  .tgt_q     (tgt_q),
  .inc_q     (inc_q),
  .in_settle (in_settle)
);

// File: tb/cntwait_unit_bench.sv
module cntwait_unit_bench;

  localparam int CW   = 8;
  localparam int WRAP = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] cnt;
  logic [CW-1:0] dst = '0;
  logic [CW-1:0] src = '0;
  logic          stall;
  logic          wb_en;
  logic [CW-1:0] wb_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  cntwait_unit #(.CW(CW)) u_cntwait_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cnt     (cnt),
    .dst     (dst),
    .src     (src),
    .stall   (stall),
    .wb_en   (wb_en),
    .wb_data (wb_data)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int due_cycle(int lead);
    return ((lead >= 3) ? lead : lead + WRAP) + 2;
  endfunction

  // Called at a falling edge (cycle 0): present the operands and the strobe.
  task automatic launch(int lead, int period, output int exp_j, output int exp_sum);
    dst     = cnt + CW'(lead);
    src     = CW'(period);
    start   = 1'b1;
    exp_j   = due_cycle(lead);
    exp_sum = (int'(dst) + period) % WRAP;
  endtask

  // poke_mode: 0 none, 1 change operands, 2 extra start pulse
  task automatic await_wb(int exp_j, int exp_sum, string req, int poke_j, int poke_mode);
    int j = 1;
    @(negedge clk);
    start = 1'b0;
    chk(stall === 1'b1, "R2 stall after start", int'(stall), 1);
    chk(wb_data === '0, "R8 wb_data zero while waiting", int'(wb_data), 0);
    while (wb_en !== 1'b1 && j < exp_j + WRAP + 8) begin
      if (j == poke_j && poke_mode == 1) begin
        dst = cnt + CW'(4);
        src = src + CW'(17);
      end
      if (j == poke_j && poke_mode == 2) begin
        dst   = cnt + CW'(4);
        start = 1'b1;
      end
      if (j == poke_j + 1) start = 1'b0;
      @(negedge clk);
      j++;
    end
    chk(j == exp_j, req, j, exp_j);
    chk(int'(wb_data) == exp_sum, "R8 wb_data sum", int'(wb_data), exp_sum);
    chk(stall === 1'b0, "R9 stall low in writeback", int'(stall), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ej;
    int es;
    repeat (3) @(negedge clk);
    chk(stall === 1'b0, "R1 reset stall", int'(stall), 0);
    chk(wb_en === 1'b0, "R1 reset wb_en", int'(wb_en), 0);
    chk(wb_data === '0, "R1 reset wb_data", int'(wb_data), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(stall === 1'b0, "R1 idle after reset", int'(stall), 0);

    // R5: shortest case, lead 3
    launch(3, 9, ej, es);
    chk(ej == 5, "R5 formula", ej, 5);
    await_wb(ej, es, "R5 six-cycle execution", -1, 0);
    @(negedge clk);
    chk(wb_en === 1'b0, "R9 single writeback pulse", int'(wb_en), 0);

    // R6 / R7: sweep every lead
    for (int lead = 0; lead < WRAP; lead++) begin
      launch(lead, (lead * 7 + 3) % WRAP, ej, es);
      await_wb(ej, es, (lead < 3) ? "R7 wrap wait cycle" : "R6 release cycle", -1, 0);
      @(negedge clk);
      chk(wb_en === 1'b0, "R9 writeback ends", int'(wb_en), 0);
    end

    // R3: operand changes during the stall are ignored
    launch(20, 5, ej, es);
    await_wb(ej, es, "R3 operands frozen release", 2, 1);
    @(negedge clk);

    // R10: start while busy is ignored
    launch(30, 11, ej, es);
    await_wb(ej, es, "R10 busy start ignored", 10, 2);
    @(negedge clk);
    chk(stall === 1'b0, "R10 no extra wait", int'(stall), 0);

    // R11: back-to-back start in the writeback cycle
    launch(10, 40, ej, es);
    await_wb(ej, es, "R11 first wait", -1, 0);
    launch(7, 2, ej, es);
    await_wb(ej, es, "R11 second wait from writeback cycle", -1, 0);
    launch(1, 6, ej, es);
    await_wb(ej, es, "R11 R7 wrap from writeback cycle", -1, 0);
    @(negedge clk);
    chk(wb_en === 1'b0 && stall === 1'b0, "R11 idle afterwards", int'(wb_en), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule